// File: doc/BRIEF.md
# Vector Length State Unit

This unit keeps the vector-length context for a prefixed vector instruction stream. It holds two 32-bit state words with one shared field layout: a global word, which applies when an instruction carries no prefix length information, and a prefix word, which is loaded per instruction from an immediate maximum-length encoding. A 12-bit length-type field that comes with each prefixed instruction selects which word governs the instruction. The unit then computes the effective vector length the way a set-length operation does, reading a scalar operand through a same-cycle register-read port. When the destination register is not x0, it issues a one-cycle write-back of the length.

While the element loop runs, each step pulse advances the source and destination element offsets of the word that is active. When the loop reaches its length, the offsets clear and a completion flag pulses. Illegal type encodings, a requested maximum beyond XLEN, and state writes that touch reserved bits all raise a registered trap. An update that traps commits nothing, so exceptions stay precise.

Top module: `vls_unit`

State word layout (both words): maxvl [5:0], vl [11:6], srcoffs [17:12], destoffs [23:18], subvl [25:24], dsvoffs [27:26], reserved [31:28].

## Requirements
- R1: After reset both state words read zero, the global word is active, the active length is 1, and trap, done and wb_valid are low.
- R2: A type field of all zeros selects the global word. rf_raddr carries the low five bits of the global vl field, which holds a register number. The active length becomes min(rf_rdata, global maxvl), or 1 when the vl field is zero or the minimum is zero. No write-back is issued and no offset changes.
- R3: A type field with bit 11 and bit 0 both set is the immediate-maximum form. The destination register is bits 10:6 and the maximum MVL is bits 5:1. The prefix word is loaded with maxvl=MVL, vl=the computed length and every other field zero, and the prefix word becomes active.
- R4: In the immediate-maximum form rf_raddr equals rs1_idx. The length is MVL when rs1_idx is zero and min(rf_rdata, MVL) otherwise. The active length is that value, or 1 when it is zero.
- R5: One cycle after an accepted immediate-maximum instruction whose destination is not zero, wb_valid pulses for one cycle with wb_idx = destination and wb_data = the computed length. A zero destination produces no pulse.
- R6: An immediate-maximum instruction with MVL greater than XLEN raises trap for one cycle on the next edge, changes neither word, and issues no write-back.
- R7: Any non-zero type field other than the immediate-maximum form raises trap and changes no state.
- R8: st_we writes st_wdata to the prefix word (st_sel=1) or the global word (st_sel=0) on the next edge. When any of bits 31:28 is set, it raises trap instead and writes nothing, so the reserved bits always read zero.
- R9: A step pulse adds one to srcoffs and destoffs of the active word and leaves the other word unchanged.
- R10: When srcoffs+1 reaches the active length, the step clears both offsets and done pulses for one cycle in that same edge. With a length of 1, every step completes.
- R11: In one cycle st_we takes precedence over instr_valid, and instr_valid takes precedence over step. A lower-priority request in that cycle is dropped with no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | A prefixed instruction is issued this cycle |
| vtype | input | 12 | Length-type field of the instruction |
| rs1_idx | input | 5 | Scalar source register number |
| rf_raddr | output | 5 | Register-read address |
| rf_rdata | input | XLEN | Register-read data, same cycle |
| wb_valid | output | 1 | Length write-back pulse |
| wb_idx | output | 5 | Write-back destination register |
| wb_data | output | XLEN | Write-back length value |
| st_we | input | 1 | State word write strobe |
| st_sel | input | 1 | 1 selects the prefix word, 0 the global word |
| st_wdata | input | 32 | State write data |
| step | input | 1 | Element-step pulse |
| gstate | output | 32 | Global state word |
| pstate | output | 32 | Prefix state word |
| act_prefix | output | 1 | Prefix word currently governs the loop |
| act_len | output | 6 | Active loop length (at least 1) |
| done | output | 1 | Loop-complete pulse |
| trap | output | 1 | Illegal-instruction trap pulse |

## Verification
Three requests can coincide in one cycle: a state write, an instruction issue and an element step. The main contention is a step that lands in the same cycle as a state write or a new instruction. The random phase sets each request independently, so all three often arrive together. Directed cycles also pair a step with a write into the active word while the loop is one step from wrapping. The bench model applies the fixed priority and expects the dropped step to leave the offsets unchanged and done low. The model expects the word written in that cycle to read back exactly as written.

// File: rtl/vls_pkg.sv
package vls_pkg;
   localparam int FW     = 6;
   localparam int REGW   = 5;
   localparam int TYPE_W = 12;
   localparam int WORD_W = 32;

   typedef struct packed {
      logic [3:0]    rsvd;
      logic [1:0]    dsvoffs;
      logic [1:0]    subvl;
      logic [FW-1:0] destoffs;
      logic [FW-1:0] srcoffs;
      logic [FW-1:0] vl;
      logic [FW-1:0] maxvl;
   } vstate_t;
endpackage

// File: rtl/vls_type_decode.sv
module vls_type_decode
   import vls_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [TYPE_W-1:0] vtype,
   output logic              is_default,
   output logic              is_imm,
   output logic              bad_enc,
   output logic              too_big,
   output logic [REGW-1:0]   rd,
   output logic [REGW-1:0]   mvl
);
   localparam int IMM_MAX = (1 << REGW) - 1;

   assign is_default = (vtype == '0);
   assign is_imm     = vtype[TYPE_W-1] & vtype[0];
   assign bad_enc    = !is_default && !is_imm;
   assign rd         = vtype[10:6];
   assign mvl        = vtype[5:1];

   // the limit check disappears when no immediate can exceed XLEN
   generate
      if (XLEN >= IMM_MAX) begin : g_no_limit
         assign too_big = 1'b0;
      end else begin : g_limit
         localparam logic [REGW:0] XL = (REGW+1)'(XLEN);
         assign too_big = is_imm && ({1'b0, mvl} > XL);
      end
   endgenerate
endmodule

// File: rtl/vls_len_calc.sv
module vls_len_calc
   import vls_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] src,
   input  logic [FW-1:0]   limit,
   input  logic            use_limit,
   output logic [FW-1:0]   len_raw,
   output logic [FW-1:0]   len_eff
);
   generate
      if (XLEN < 8) begin : g_bad_xlen
         $error("vls_len_calc: XLEN must be at least 8");
      end
   endgenerate

   logic over;
   assign over    = (src[XLEN-1:FW] != '0) || (src[FW-1:0] > limit);
   assign len_raw = (use_limit || over) ? limit : src[FW-1:0];
   assign len_eff = (len_raw == '0) ? FW'(1) : len_raw;
endmodule

// File: rtl/vls_offset_step.sv
module vls_offset_step
   import vls_pkg::*;
(
   input  vstate_t       cur,
   input  logic          step,
   input  logic [FW-1:0] len,
   output vstate_t       nxt,
   output logic          wrap
);
   logic [FW:0] src_inc;
   assign src_inc = {1'b0, cur.srcoffs} + (FW+1)'(1);
   assign wrap    = step && (src_inc >= {1'b0, len});

   always_comb begin
      nxt = cur;
      if (step) begin
         if (wrap) begin
            nxt.srcoffs  = '0;
            nxt.destoffs = '0;
         end else begin
            nxt.srcoffs  = src_inc[FW-1:0];
            nxt.destoffs = cur.destoffs + FW'(1);
         end
      end
   end
endmodule

// File: rtl/vls_unit.sv
module vls_unit
   import vls_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [11:0]       vtype,
   input  logic [4:0]        rs1_idx,
   output logic [4:0]        rf_raddr,
   input  logic [XLEN-1:0]   rf_rdata,
   output logic              wb_valid,
   output logic [4:0]        wb_idx,
   output logic [XLEN-1:0]   wb_data,
   input  logic              st_we,
   input  logic              st_sel,
   input  logic [31:0]       st_wdata,
   input  logic              step,
   output logic [31:0]       gstate,
   output logic [31:0]       pstate,
   output logic              act_prefix,
   output logic [5:0]        act_len,
   output logic              done,
   output logic              trap
);
   localparam int NWORD = 2;
   localparam int RSV_LO = WORD_W - 4;

   generate
      if (XLEN < 8 || XLEN > 1024) begin : g_bad_param
         $error("vls_unit: XLEN out of supported range");
      end
   endgenerate

   vstate_t          g_q, p_q, g_d, p_d;
   logic             ap_q, ap_d;
   logic [FW-1:0]    len_q, len_d;
   logic             trap_q, trap_d, done_q, done_d;
   logic             wbv_q, wbv_d;
   logic [REGW-1:0]  wbi_q, wbi_d;
   logic [XLEN-1:0]  wbx_q, wbx_d;

   // decode of the length-type field
   logic            dec_default, dec_imm, dec_bad, dec_big;
   logic [REGW-1:0] dec_rd, dec_mvl;

   vls_type_decode #(.XLEN(XLEN)) u_dec (
      .vtype      (vtype),
      .is_default (dec_default),
      .is_imm     (dec_imm),
      .bad_enc    (dec_bad),
      .too_big    (dec_big),
      .rd         (dec_rd),
      .mvl        (dec_mvl)
   );

   // register read and length computation
   logic [FW-1:0] lim, len_raw, len_eff;
   logic          use_lim;

   assign rf_raddr = dec_default ? g_q.vl[REGW-1:0] : rs1_idx;
   assign lim      = dec_default ? g_q.maxvl : {1'b0, dec_mvl};
   assign use_lim  = !dec_default && (rs1_idx == '0);

   vls_len_calc #(.XLEN(XLEN)) u_len (
      .src       (rf_rdata),
      .limit     (lim),
      .use_limit (use_lim),
      .len_raw   (len_raw),
      .len_eff   (len_eff)
   );

   // one offset stepper per state word
   vstate_t cur_a [NWORD];
   vstate_t nxt_a [NWORD];
   logic    wrap_a [NWORD];

   assign cur_a[0] = g_q;
   assign cur_a[1] = p_q;

   generate
      for (genvar i = 0; i < NWORD; i++) begin : g_step
         vls_offset_step u_step (
            .cur  (cur_a[i]),
            .step (step),
            .len  (len_q),
            .nxt  (nxt_a[i]),
            .wrap (wrap_a[i])
         );
      end
   endgenerate

   logic wr_rsvd_bad;
   assign wr_rsvd_bad = (st_wdata[WORD_W-1:RSV_LO] != '0);

   // priority: state write, then instruction, then element step
   always_comb begin
      g_d    = g_q;
      p_d    = p_q;
      ap_d   = ap_q;
      len_d  = len_q;
      trap_d = 1'b0;
      done_d = 1'b0;
      wbv_d  = 1'b0;
      wbi_d  = '0;
      wbx_d  = '0;
      if (st_we) begin
         if (wr_rsvd_bad)  trap_d = 1'b1;
         else if (st_sel)  p_d = vstate_t'(st_wdata);
         else              g_d = vstate_t'(st_wdata);
      end else if (instr_valid) begin
         if (dec_default) begin
            ap_d  = 1'b0;
            len_d = (g_q.vl == '0) ? FW'(1) : len_eff;
         end else if (dec_bad || dec_big) begin
            trap_d = 1'b1;
         end else begin
            p_d       = '0;
            p_d.maxvl = {1'b0, dec_mvl};
            p_d.vl    = len_raw;
            ap_d      = 1'b1;
            len_d     = len_eff;
            if (dec_rd != '0) begin
               wbv_d = 1'b1;
               wbi_d = dec_rd;
               wbx_d = {{(XLEN-FW){1'b0}}, len_raw};
            end
         end
      end else if (step) begin
         if (ap_q) begin
            p_d    = nxt_a[1];
            done_d = wrap_a[1];
         end else begin
            g_d    = nxt_a[0];
            done_d = wrap_a[0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         g_q    <= '0;
         p_q    <= '0;
         ap_q   <= 1'b0;
         len_q  <= FW'(1);
         trap_q <= 1'b0;
         done_q <= 1'b0;
         wbv_q  <= 1'b0;
         wbi_q  <= '0;
         wbx_q  <= '0;
      end else begin
         g_q    <= g_d;
         p_q    <= p_d;
         ap_q   <= ap_d;
         len_q  <= len_d;
         trap_q <= trap_d;
         done_q <= done_d;
         wbv_q  <= wbv_d;
         wbi_q  <= wbi_d;
         wbx_q  <= wbx_d;
      end
   end

   assign gstate     = g_q;
   assign pstate     = p_q;
   assign act_prefix = ap_q;
   assign act_len    = len_q;
   assign done       = done_q;
   assign trap       = trap_q;
   assign wb_valid   = wbv_q;
   assign wb_idx     = wbi_q;
   assign wb_data    = wbx_q;
endmodule

// File: rtl/vls_checker.sv
module vls_checker
   import vls_pkg::*;
#(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic [31:0]     gstate,
   input logic [31:0]     pstate,
   input logic            act_prefix,
   input logic [5:0]      act_len,
   input logic            trap,
   input logic            done,
   input logic            wb_valid,
   input logic [4:0]      wb_idx,
   input logic [XLEN-1:0] wb_data
);
   vstate_t gs, ps;
   assign gs = vstate_t'(gstate);
   assign ps = vstate_t'(pstate);

   // R8: reserved bits never read non-zero
   p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (gs.rsvd == '0) && (ps.rsvd == '0));

   // R6: a trapped update leaves both words untouched
   p_trap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> ($stable(gstate) && $stable(pstate)));

   // R5: write-back never targets register zero
   p_wb_rd_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (wb_idx != '0));

   // R4: written-back length never exceeds the prefix maximum
   p_wb_vl_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> ((wb_data[XLEN-1:FW] == '0) && (wb_data[FW-1:0] <= ps.maxvl)
                    && (wb_data[FW-1:0] == ps.vl)));

   // R3: a write-back comes with the prefix word active
   p_wb_prefix_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> act_prefix);

   // R10: completion leaves the active offsets at zero
   p_done_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (act_prefix ? (ps.srcoffs == '0 && ps.destoffs == '0)
                           : (gs.srcoffs == '0 && gs.destoffs == '0)));

   // R10: active length is never zero
   p_len_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      act_len != '0);

   // R11: one request per cycle takes effect
   p_one_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({trap, done, wb_valid}) <= 1);
endmodule

bind vls_unit vls_checker #(.XLEN(XLEN)) u_vls_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .gstate     (gstate),
   .pstate     (pstate),
   .act_prefix (act_prefix),
   .act_len    (act_len),
   .trap       (trap),
   .done       (done),
   .wb_valid   (wb_valid),
   .wb_idx     (wb_idx),
   .wb_data    (wb_data)
);

// File: tb/vls_unit_test.sv
module vls_unit_test;
   localparam int XL = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          instr_valid = 1'b0;
   logic [11:0]   vtype = '0;
   logic [4:0]    rs1_idx = '0;
   logic [4:0]    rf_raddr;
   logic [XL-1:0] rf_rdata;
   logic          wb_valid;
   logic [4:0]    wb_idx;
   logic [XL-1:0] wb_data;
   logic          st_we = 1'b0;
   logic          st_sel = 1'b0;
   logic [31:0]   st_wdata = '0;
   logic          step = 1'b0;
   logic [31:0]   gstate, pstate;
   logic          act_prefix;
   logic [5:0]    act_len;
   logic          done, trap;

   logic [XL-1:0] regs [32];
   assign rf_rdata = regs[rf_raddr];

   always #5 clk = ~clk;

   vls_unit #(.XLEN(XL)) uut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .vtype(vtype),
      .rs1_idx(rs1_idx), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
      .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
      .st_we(st_we), .st_sel(st_sel), .st_wdata(st_wdata), .step(step),
      .gstate(gstate), .pstate(pstate), .act_prefix(act_prefix),
      .act_len(act_len), .done(done), .trap(trap)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // model state
   logic [31:0] m_g, m_p;
   logic        m_ap;
   int          m_len;

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int min_len(input int v, input int lim);
      return (v > lim) ? lim : v;
   endfunction

   task automatic run(input logic iv, input logic [11:0] vt, input logic [4:0] rs,
                      input logic we, input logic sel, input logic [31:0] wd,
                      input logic stp);
      logic [31:0] eg, ep, cur;
      logic        eap, etrap, edone, ewb;
      int          elen, r, mvl, s;
      logic [4:0]  eidx, eaddr;
      string       tag;
      eg = m_g; ep = m_p; eap = m_ap; elen = m_len;
      etrap = 0; edone = 0; ewb = 0; eidx = 0; r = 0; tag = "R11";
      eaddr = (vt == 0) ? m_g[10:6] : rs;

      @(negedge clk);
      instr_valid = iv; vtype = vt; rs1_idx = rs;
      st_we = we; st_sel = sel; st_wdata = wd; step = stp;
      #1;
      if (iv) chk((vt == 0) ? "R2" : "R4", "rf_raddr", 64'(rf_raddr), 64'(eaddr));

      if (we) begin
         tag = (iv || stp) ? "R11" : "R8";
         if (wd[31:28] != 0) etrap = 1;
         else if (sel) ep = wd;
         else eg = wd;
      end else if (iv) begin
         if (vt == 0) begin
            tag = (stp) ? "R11" : "R2";
            eap = 0;
            if (m_g[11:6] == 0) elen = 1;
            else begin
               r = min_len(int'(regs[m_g[10:6]]), int'(m_g[5:0]));
               elen = (r == 0) ? 1 : r;
            end
         end else if (vt[11] && vt[0]) begin
            mvl = int'(vt[5:1]);
            if (mvl > XL) begin
               tag = "R6"; etrap = 1;
            end else begin
               tag = (rs == 0) ? "R3" : "R4";
               r = (rs == 0) ? mvl : min_len(int'(regs[rs]), mvl);
               ep = {20'd0, 6'(r), 6'(mvl)};
               eap = 1;
               elen = (r == 0) ? 1 : r;
               if (vt[10:6] != 0) begin ewb = 1; eidx = vt[10:6]; end
            end
         end else begin
            tag = "R7"; etrap = 1;
         end
      end else if (stp) begin
         tag = "R9";
         cur = m_ap ? m_p : m_g;
         s = int'(cur[17:12]);
         if (s + 1 >= m_len) begin
            cur[23:12] = '0; edone = 1;
         end else begin
            cur[17:12] = 6'(s + 1);
            cur[23:18] = cur[23:18] + 6'd1;
         end
         if (m_ap) ep = cur; else eg = cur;
      end

      @(posedge clk); #1;
      chk(tag, "gstate", 64'(gstate), 64'(eg));
      chk(tag, "pstate", 64'(pstate), 64'(ep));
      chk(tag, "act_prefix", 64'(act_prefix), 64'(eap));
      chk(tag, "act_len", 64'(act_len), 64'(elen));
      chk(etrap ? ((tag == "R11") ? "R8" : tag) : tag, "trap", 64'(trap), 64'(etrap));
      chk(stp ? "R10" : "R11", "done", 64'(done), 64'(edone));
      chk("R5", "wb_valid", 64'(wb_valid), 64'(ewb));
      if (ewb) begin
         chk("R5", "wb_idx", 64'(wb_idx), 64'(eidx));
         chk("R5", "wb_data", 64'(wb_data), 64'(r));
      end
      m_g = eg; m_p = ep; m_ap = eap; m_len = elen;
      instr_valid = 0; st_we = 0; step = 0;
   endtask

   task automatic idle();
      run(0, '0, '0, 0, 0, '0, 0);
   endtask

   function automatic logic [11:0] imm(input int rd, input int mvl);
      return {1'b1, 5'(rd), 5'(mvl), 1'b1};
   endfunction

   initial begin
      #(10 * 150000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 32; i++) regs[i] = (i == 0) ? '0 : XL'(i + 2);
      m_g = '0; m_p = '0; m_ap = 0; m_len = 1;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1", "gstate", 64'(gstate), 64'd0);
      chk("R1", "pstate", 64'(pstate), 64'd0);
      chk("R1", "act_prefix", 64'(act_prefix), 64'd0);
      chk("R1", "act_len", 64'(act_len), 64'd1);
      chk("R1", "trap/done/wb", 64'({trap, done, wb_valid}), 64'd0);

      // R3/R5: immediate form, rs1 zero, rd 3, MVL 10
      run(1, imm(3, 10), 5'd0, 0, 0, '0, 0);
      idle();
      // R4: rs1 = 5 holds 7, MVL 10 -> 7, rd zero -> no write-back
      run(1, imm(0, 10), 5'd5, 0, 0, '0, 0);
      // R9/R10: six steps then wrap on the seventh
      for (int k = 0; k < 7; k++) run(0, '0, '0, 0, 0, '0, 1);
      // R6: MVL 20 beyond XLEN
      run(1, imm(4, 20), 5'd0, 0, 0, '0, 0);
      // R6 boundary: MVL equal to XLEN is legal
      run(1, imm(4, 16), 5'd0, 0, 0, '0, 0);
      // R7: bit 11 clear, non-zero
      run(1, 12'h001, 5'd1, 0, 0, '0, 0);
      run(1, 12'h802, 5'd1, 0, 0, '0, 0);
      // R8: reserved bit write traps, legal write lands
      run(0, '0, '0, 1, 0, 32'h1000_0000, 0);
      regs[7] = XL'(100);
      run(0, '0, '0, 1, 0, {20'd0, 6'd7, 6'd8}, 0);
      // R2: default form, clamped to global maxvl 8
      run(1, '0, 5'd9, 0, 0, '0, 0);
      for (int k = 0; k < 7; k++) run(0, '0, '0, 0, 0, '0, 1);
      // R11: step with write into the active word on the wrap step
      run(0, '0, '0, 1, 0, {14'd0, 6'd7, 6'd7, 6'd8}, 1);
      chk("R11", "done dropped", 64'(done), 64'd0);
      run(1, imm(2, 3), 5'd0, 0, 0, '0, 1);
      chk("R11", "offsets after dropped step", 64'(pstate[23:12]), 64'd0);
      // R2: vl field zero means scalar
      run(0, '0, '0, 1, 0, 32'h0000_0005, 0);
      run(1, '0, 5'd0, 0, 0, '0, 0);
      run(0, '0, '0, 0, 0, '0, 1);

      // random phase
      for (int n = 0; n < 4000; n++) begin
         logic iv, we, stp, sel;
         logic [11:0] vt;
         logic [31:0] wd;
         int pick;
         if ((n % 97) == 0)
            for (int i = 1; i < 32; i++)
               regs[i] = ($urandom_range(0, 3) == 0) ? XL'($urandom) : XL'($urandom_range(0, 40));
         iv  = ($urandom_range(0, 3) == 0);
         we  = ($urandom_range(0, 9) == 0);
         stp = ($urandom_range(0, 1) == 0);
         sel = $urandom_range(0, 1);
         pick = $urandom_range(0, 9);
         if (pick < 6)      vt = imm($urandom_range(0, 31), $urandom_range(0, 31));
         else if (pick < 8) vt = '0;
         else               vt = 12'($urandom);
         wd = $urandom;
         if ($urandom_range(0, 3) != 0) wd[31:28] = '0;
         wd[11:6] = 6'($urandom_range(0, 31));
         run(iv, vt, 5'($urandom_range(0, 31)), we, sel, wd, stp);
      end

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule